// File: doc/BRIEF.md
# Ring-Chained FIFO Slice

This block is one slice of a queue that can be made deeper by chaining identical copies. Each slice holds `DEPTH` words of storage. Two ownership tokens, one for writing and one for reading, travel around the chain. A slice accepts writes only while it holds the write token and returns data only while it holds the read token. Every slice sees the same write enable, write data and read enable. Because the tokens arrive in the same order in which the storage fills, the chain as a whole behaves as one first-in first-out queue of `N * DEPTH` words.

A strap input picks the slice that owns both tokens when reset ends. When a slice writes its last location, it raises its write hand-off output in that same cycle and gives up the write token. The next slice samples that output on the same clock edge and takes the token. Reads hand over in the same way. The last slice feeds the first, so the chain forms a ring. A slice that returns no word in a cycle drives zeros and a low valid. The outputs of all slices can therefore be OR-ed into one chain output. The AND of the per-slice empty flags gives the chain empty flag, and the AND of the per-slice full flags gives the chain full flag.

When the `MODE` parameter selects stand-alone operation, both tokens are held at all times and the storage works as an ordinary circular buffer. In that mode the write hand-off output carries a more-than-half-full flag instead.

Top module: `chain_fifo_slice`

## Requirements
- R1: While reset is asserted and in the cycle after it is released, each slice shows empty=1, full=0, rd_valid=0, rd_data=0, wx_out=0 and rx_out=0. Only the slice with first_n=0 holds both tokens, so the first words written land in that slice.
- R2: A write is accepted only when wr_en=1, the slice holds the write token and the slice is not full. A slice without the write token ignores wr_en, and its empty flag stays 1.
- R3: In chain mode, wx_out is 1 during exactly the cycle in which a write to the last location (index DEPTH-1) is accepted. From the next cycle the slice no longer holds the write token and refuses further writes.
- R4: In chain mode, rx_out is 1 during exactly the cycle in which a read from the last location (index DEPTH-1) is accepted. From the next cycle the slice no longer holds the read token.
- R5: A 1 on wx_in (or rx_in) sampled at a clock edge gives the slice the write (or read) token from that edge on. If a hand-off in and a hand-off out happen at the same edge, the slice keeps the token.
- R6: In the cycle after an accepted read, rd_valid=1 and rd_data holds the word read. In every other cycle rd_valid=0 and rd_data is all zeros.
- R7: A read is accepted only when rd_en=1, the slice holds the read token and the slice is not empty. A read request while the queue is empty produces no valid output.
- R8: A ring of slices returns words in the order they were written, including when simultaneous reads and writes carry the tokens around the ring several times.
- R9: With MODE=SLICE_SOLO, both tokens are always held, the pointers wrap around, rx_out stays 0, and wx_out is 1 exactly when the stored count is greater than DEPTH/2.
- R10: full=1 exactly when DEPTH words are stored, and a write requested while full is dropped. The AND of the full flags of all slices in a ring equals the chain being full.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for both the write side and the read side |
| rst_n | input | 1 | Asynchronous active-low reset |
| first_n | input | 1 | Strap; 0 marks the slice that owns both tokens after reset |
| wr_en | input | 1 | Write request, shared by all slices of a chain |
| wr_data | input | WIDTH | Write word, shared by all slices |
| rd_en | input | 1 | Read request, shared by all slices |
| wx_in | input | 1 | Write token arrival from the previous slice |
| rx_in | input | 1 | Read token arrival from the previous slice |
| wx_out | output | 1 | Write token hand-off (chain mode) or more-than-half-full flag (stand-alone) |
| rx_out | output | 1 | Read token hand-off to the next slice |
| rd_data | output | WIDTH | Word read in the previous cycle; zero when rd_valid is 0 |
| rd_valid | output | 1 | rd_data carries a word from this slice |
| empty | output | 1 | No words stored in this slice |
| full | output | 1 | DEPTH words stored in this slice |

## Verification
The bound checker watches, on every cycle, how the tokens react to the hand-off pins. It checks that a hand-off out drops the token, that a hand-off in grants it, and that a hand-off out only ever happens together with a write the slice was allowed to make. It also checks that an idle data output stays at zero, that no valid word follows an empty cycle, that a full slice holds its level when nothing is read, and that empty and full are never both set. Only the bench can show what a single slice cannot: that three slices joined in a ring return words in write order across several trips of the tokens, that the composite full flag refuses the extra word, and that the half-full flag in stand-alone mode switches at the right count.

// File: rtl/chain_fifo_pkg.sv
package chain_fifo_pkg;
  typedef enum logic [0:0] {
    SLICE_SOLO  = 1'b0,
    SLICE_CHAIN = 1'b1
  } slice_mode_e;
endpackage

// File: rtl/chain_xfer_ctl.sv
// One transfer side (write or read): pointer, ownership token, hand-off pulse.
module chain_xfer_ctl
  import chain_fifo_pkg::*;
#(
  parameter int          DEPTH = 8,
  parameter slice_mode_e MODE  = SLICE_CHAIN,
  localparam int         PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          own_at_reset,
  input  logic          req,
  input  logic          room,
  input  logic          tok_in,
  output logic [PW-1:0] ptr,
  output logic          fire,
  output logic          pass,
  output logic          tok
);

  logic [PW-1:0] ptr_q, ptr_d;
  logic          at_last;

  assign at_last = (ptr_q == PW'(DEPTH - 1));
  assign fire    = req & tok & room;
  assign ptr     = ptr_q;

  always_comb begin
    ptr_d = ptr_q;
    if (fire) begin
      if (at_last) ptr_d = '0;
      else         ptr_d = ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  generate
    if (MODE == SLICE_CHAIN) begin : g_token
      logic tok_q, tok_d;

      always_comb begin
        tok_d = tok_q;
        if (fire && at_last) tok_d = 1'b0;
        if (tok_in)          tok_d = 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tok_q <= own_at_reset;
        else        tok_q <= tok_d;
      end

      assign tok  = tok_q;
      assign pass = fire & at_last;
    end else begin : g_free
      assign tok  = 1'b1;
      assign pass = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/chain_slice_level.sv
// Occupancy counter and level flags of one slice.
module chain_slice_level #(
  parameter int  DEPTH = 8,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic inc,
  input  logic dec,
  output logic full,
  output logic empty,
  output logic half
);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (inc && !dec)      cnt_d = cnt_q + 1'b1;
    else if (dec && !inc) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign full  = (cnt_q == CW'(DEPTH));
  assign empty = (cnt_q == '0);
  assign half  = (cnt_q >  CW'(DEPTH / 2));

endmodule

// File: rtl/chain_slice_store.sv
// Word storage with a registered read port that idles at zero.
module chain_slice_store #(
  parameter int  WIDTH = 16,
  parameter int  DEPTH = 8,
  localparam int PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [PW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             re,
  input  logic [PW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata,
  output logic             rvalid
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [WIDTH-1:0] rdata_q, rdata_d;
  logic             rvalid_q, rvalid_d;

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_comb begin
    rvalid_d = re;
    rdata_d  = '0;
    if (re) rdata_d = mem[raddr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rdata_q  <= rdata_d;
      rvalid_q <= rvalid_d;
    end
  end

  assign rdata  = rdata_q;
  assign rvalid = rvalid_q;

endmodule

// File: rtl/chain_fifo_slice.sv
// One slice of a token-ring FIFO chain (or a stand-alone FIFO).
module chain_fifo_slice
  import chain_fifo_pkg::*;
#(
  parameter int          WIDTH = 16,
  parameter int          DEPTH = 8,
  parameter slice_mode_e MODE  = SLICE_CHAIN,
  localparam int         PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             first_n,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  input  logic             wx_in,
  input  logic             rx_in,
  output logic             wx_out,
  output logic             rx_out,
  output logic [WIDTH-1:0] rd_data,
  output logic             rd_valid,
  output logic             empty,
  output logic             full
);

  logic [PW-1:0] wr_ptr, rd_ptr;
  logic          wr_fire, rd_fire;
  logic          wr_pass, rd_pass;
  logic          wr_tok, rd_tok;
  logic          lvl_full, lvl_empty, lvl_half;

  chain_xfer_ctl #(.DEPTH(DEPTH), .MODE(MODE)) u_wr_side (
    .clk          (clk),
    .rst_n        (rst_n),
    .own_at_reset (~first_n),
    .req          (wr_en),
    .room         (~lvl_full),
    .tok_in       (wx_in),
    .ptr          (wr_ptr),
    .fire         (wr_fire),
    .pass         (wr_pass),
    .tok          (wr_tok)
  );

  chain_xfer_ctl #(.DEPTH(DEPTH), .MODE(MODE)) u_rd_side (
    .clk          (clk),
    .rst_n        (rst_n),
    .own_at_reset (~first_n),
    .req          (rd_en),
    .room         (~lvl_empty),
    .tok_in       (rx_in),
    .ptr          (rd_ptr),
    .fire         (rd_fire),
    .pass         (rd_pass),
    .tok          (rd_tok)
  );

  chain_slice_level #(.DEPTH(DEPTH)) u_level (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (wr_fire),
    .dec   (rd_fire),
    .full  (lvl_full),
    .empty (lvl_empty),
    .half  (lvl_half)
  );

  chain_slice_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (wr_fire),
    .waddr  (wr_ptr),
    .wdata  (wr_data),
    .re     (rd_fire),
    .raddr  (rd_ptr),
    .rdata  (rd_data),
    .rvalid (rd_valid)
  );

  assign wx_out = (MODE == SLICE_CHAIN) ? wr_pass : lvl_half;
  assign rx_out = rd_pass;
  assign empty  = lvl_empty;
  assign full   = lvl_full;

endmodule

// File: rtl/chain_fifo_slice_chk.sv
// Protocol checker bound to every chain_fifo_slice.
module chain_fifo_slice_chk
  import chain_fifo_pkg::*;
#(
  parameter int          WIDTH = 16,
  parameter slice_mode_e MODE  = SLICE_CHAIN
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic             rd_en,
  input logic             wx_in,
  input logic             rx_in,
  input logic             wx_out,
  input logic             rx_out,
  input logic [WIDTH-1:0] rd_data,
  input logic             rd_valid,
  input logic             empty,
  input logic             full,
  input logic             wr_tok,
  input logic             rd_tok
);

  p_quiet_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |-> (rd_data == '0))
    else $error("idle slice drives nonzero data");

  p_no_read_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    empty |=> !rd_valid)
    else $error("valid word after an empty cycle");

  p_hold_full_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !rd_en) |=> full)
    else $error("full slice lost level without a read");

  p_flags_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(empty && full))
    else $error("empty and full together");

  generate
    if (MODE == SLICE_CHAIN) begin : g_chain
      p_write_needs_token_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wx_out |-> (wr_tok && wr_en))
        else $error("write hand-off without an allowed write");

      p_wx_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wx_out && !wx_in) |=> !wr_tok)
        else $error("write token kept after hand-off");

      p_rx_pass_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_out && !rx_in) |=> !rd_tok)
        else $error("read token kept after hand-off");

      p_wx_grant_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wx_in |=> wr_tok)
        else $error("write token not taken");

      p_rx_grant_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_in |=> rd_tok)
        else $error("read token not taken");
    end else begin : g_solo
      p_solo_rx_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_out)
        else $error("read hand-off in stand-alone mode");
    end
  endgenerate

endmodule

bind chain_fifo_slice chain_fifo_slice_chk #(.WIDTH(WIDTH), .MODE(MODE)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_en    (wr_en),
  .rd_en    (rd_en),
  .wx_in    (wx_in),
  .rx_in    (rx_in),
  .wx_out   (wx_out),
  .rx_out   (rx_out),
  .rd_data  (rd_data),
  .rd_valid (rd_valid),
  .empty    (empty),
  .full     (full),
  .wr_tok   (wr_tok),
  .rd_tok   (rd_tok)
);

// File: tb/chain_fifo_slice_test.sv
`timescale 1ns/1ps
module chain_fifo_slice_test;
  import chain_fifo_pkg::*;

  localparam int W   = 16;
  localparam int D   = 4;
  localparam int NS  = 3;
  localparam int CAP = NS * D;

  logic clk = 1'b0;
  logic rst_n;
  always #2.5 clk = ~clk;

  // shared chain stimulus
  logic         wr_en, rd_en;
  logic [W-1:0] wr_data;
  // per-slice outputs
  logic [NS-1:0] s_wxo, s_rxo, s_emp, s_full, s_val;
  logic [W-1:0]  s_dat [NS];

  for (genvar k = 0; k < NS; k++) begin : g_ring
    chain_fifo_slice #(.WIDTH(W), .DEPTH(D), .MODE(SLICE_CHAIN)) uut (
      .clk      (clk),
      .rst_n    (rst_n),
      .first_n  (k != 0),
      .wr_en    (wr_en),
      .wr_data  (wr_data),
      .rd_en    (rd_en),
      .wx_in    (s_wxo[(k + NS - 1) % NS]),
      .rx_in    (s_rxo[(k + NS - 1) % NS]),
      .wx_out   (s_wxo[k]),
      .rx_out   (s_rxo[k]),
      .rd_data  (s_dat[k]),
      .rd_valid (s_val[k]),
      .empty    (s_emp[k]),
      .full     (s_full[k])
    );
  end

  logic [W-1:0] ch_data;
  logic         ch_valid, ch_empty, ch_full;
  assign ch_data  = s_dat[0] | s_dat[1] | s_dat[2];
  assign ch_valid = |s_val;
  assign ch_empty = &s_emp;
  assign ch_full  = &s_full;

  // stand-alone instance
  logic         so_wr_en, so_rd_en;
  logic [W-1:0] so_wr_data, so_rd_data;
  logic         so_wxo, so_rxo, so_val, so_emp, so_full;

  chain_fifo_slice #(.WIDTH(W), .DEPTH(D), .MODE(SLICE_SOLO)) uut_solo (
    .clk      (clk),
    .rst_n    (rst_n),
    .first_n  (1'b0),
    .wr_en    (so_wr_en),
    .wr_data  (so_wr_data),
    .rd_en    (so_rd_en),
    .wx_in    (1'b0),
    .rx_in    (1'b0),
    .wx_out   (so_wxo),
    .rx_out   (so_rxo),
    .rd_data  (so_rd_data),
    .rd_valid (so_val),
    .empty    (so_emp),
    .full     (so_full)
  );

  int n_chk  = 0;
  int n_fail = 0;
  logic [W-1:0] q  [$];
  logic [W-1:0] sq [$];
  logic [W-1:0] seq = 16'h1000;
  logic [NS-1:0] pre_wx, pre_rx;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // one chain cycle: drive at negedge, sample hand-offs before the edge, outputs after it
  task automatic cyc(input bit w, input logic [W-1:0] d, input bit r);
    bit w_ok, r_ok;
    @(negedge clk);
    wr_en = w; wr_data = d; rd_en = r;
    #0.5;
    pre_wx = s_wxo;
    pre_rx = s_rxo;
    w_ok = w && (q.size() < CAP);
    r_ok = r && (q.size() > 0);
    @(posedge clk);
    #1;
    if (r_ok) begin
      chk(ch_valid && ch_data == q[0], "R8 order", {ch_valid, ch_data}, {1'b1, q[0]});
      void'(q.pop_front());
    end else begin
      chk(!ch_valid && ch_data == '0, "R6 idle output", {ch_valid, ch_data}, 0);
    end
    if (w_ok) q.push_back(d);
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
  endtask

  task automatic s_cyc(input bit w, input logic [W-1:0] d, input bit r);
    bit w_ok, r_ok;
    @(negedge clk);
    so_wr_en = w; so_wr_data = d; so_rd_en = r;
    w_ok = w && (sq.size() < D);
    r_ok = r && (sq.size() > 0);
    @(posedge clk);
    #1;
    if (r_ok) begin
      chk(so_val && so_rd_data == sq[0], "R9 solo order", {so_val, so_rd_data}, {1'b1, sq[0]});
      void'(sq.pop_front());
    end else begin
      chk(!so_val, "R6 solo idle", so_val, 0);
    end
    if (w_ok) sq.push_back(d);
    chk(so_wxo == (sq.size() > D / 2), "R9 half flag", so_wxo, sq.size() > D / 2);
    chk(!so_rxo, "R9 no read hand-off", so_rxo, 0);
    @(negedge clk);
    so_wr_en = 1'b0; so_rd_en = 1'b0;
  endtask

  task automatic t_reset;
    chk(ch_empty, "R1 empty", ch_empty, 1);
    chk(s_full == '0, "R1 full", s_full, 0);
    chk(!ch_valid && ch_data == '0, "R1 data", ch_data, 0);
    chk(s_wxo == '0 && s_rxo == '0, "R1 hand-offs", {s_wxo, s_rxo}, 0);
    chk(so_emp && !so_full && !so_wxo, "R1 solo flags", {so_emp, so_full, so_wxo}, 3'b100);
  endtask

  task automatic t_tokens;
    for (int i = 0; i < D; i++) begin
      cyc(1'b1, seq, 1'b0); seq++;
      chk(pre_wx == ((i == D - 1) ? 3'b001 : 3'b000), "R3 write hand-off", pre_wx,
          (i == D - 1) ? 3'b001 : 3'b000);
    end
    chk(s_full[0], "R1 first slice filled", s_full[0], 1);
    chk(s_emp[1] && s_emp[2], "R2 no token ignores writes", s_emp, 3'b110);
    cyc(1'b1, seq, 1'b0); seq++;
    chk(pre_wx == '0, "R5 no early hand-off", pre_wx, 0);
    chk(!s_emp[1], "R5 token taken by next slice", s_emp[1], 0);
    chk(s_full[0] && s_emp[2], "R3 old owner refuses", {s_full[0], s_emp[2]}, 2'b11);
  endtask

  task automatic t_drain;
    for (int i = 0; i < D + 1; i++) begin
      cyc(1'b0, '0, 1'b1);
      chk(pre_rx == ((i == D - 1) ? 3'b001 : 3'b000), "R4 read hand-off", pre_rx,
          (i == D - 1) ? 3'b001 : 3'b000);
    end
    chk(ch_empty, "R7 chain empty", ch_empty, 1);
  endtask

  task automatic t_empty_read;
    cyc(1'b0, '0, 1'b1);
    cyc(1'b0, '0, 1'b1);
    chk(ch_empty && !ch_valid, "R7 read while empty", {ch_empty, ch_valid}, 2'b10);
  endtask

  task automatic t_fill;
    for (int i = 0; i < CAP; i++) begin
      cyc(1'b1, seq, 1'b0); seq++;
    end
    chk(ch_full, "R10 composite full", ch_full, 1);
    cyc(1'b1, 16'hDEAD, 1'b0);
    chk(ch_full && q.size() == CAP, "R10 extra write dropped", ch_full, 1);
    for (int i = 0; i < CAP + 1; i++) cyc(1'b0, '0, 1'b1);
    chk(ch_empty, "R10 drained", ch_empty, 1);
  endtask

  task automatic t_stream;
    for (int i = 0; i < 5; i++) begin
      cyc(1'b1, seq, 1'b0); seq++;
    end
    for (int i = 0; i < 30; i++) begin
      cyc(1'b1, seq, 1'b1); seq++;
    end
    for (int i = 0; i < 6; i++) cyc(1'b0, '0, 1'b1);
    chk(ch_empty && q.size() == 0, "R8 ring stream drained", ch_empty, 1);
  endtask

  task automatic t_solo;
    for (int i = 0; i < D + 1; i++) begin
      s_cyc(1'b1, 16'h5000 + 16'(i), 1'b0);
    end
    chk(so_full, "R10 solo full", so_full, 1);
    for (int i = 0; i < D; i++) s_cyc(1'b0, '0, 1'b1);
    for (int i = 0; i < 3; i++) s_cyc(1'b1, 16'h6000 + 16'(i), 1'b0);
    for (int i = 0; i < 4; i++) s_cyc(1'b0, '0, 1'b1);
    chk(so_emp, "R9 solo wrap drained", so_emp, 1);
  endtask

  initial begin
    rst_n = 1'b0;
    wr_en = 1'b0; rd_en = 1'b0; wr_data = '0;
    so_wr_en = 1'b0; so_rd_en = 1'b0; so_wr_data = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    t_reset;
    t_tokens;
    t_drain;
    t_empty_read;
    t_fill;
    t_stream;
    t_solo;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule